// File: doc/BRIEF.md
# Delay-Slot Branch Resolver with Likely-Form Squash

This unit settles conditional branches for a small in-order core that has one delay slot. It accepts one instruction per cycle, together with the PC of that instruction and the two source register values the core has read for it. One cycle later it reports whether the instruction was a taken branch, the branch target, whether the delay slot is cancelled, and the PC to fetch next. It also keeps a running count of retired instructions.

Both the plain and the "likely" forms of branch-on-equal and branch-on-not-equal are handled. A plain branch always runs its delay slot. A likely branch runs its delay slot only when it is taken. When it is not taken, the slot is cancelled and fetch skips over it. The cancel condition is built as an OR of per-instruction not-taken terms, so more likely forms can be added later as further terms. Opcodes outside a small allow-list, and any branch placed in a delay slot, stop the unit. The unit then records the PC and the instruction word of the fault.

Top module: `branch_slot_unit`

## Requirements
- R1: After synchronous reset, out_valid, out_taken, out_squash, out_unsup and halted are 0, and retire_count, out_next_pc, out_target, fault_pc and fault_instr are 0.
- R2: The opcode sits in instr[31:25+1], which is bits 31:26. The four branches are 0x04 (branch if equal), 0x05 (branch if not equal), 0x14 (equal, likely form) and 0x15 (not equal, likely form). The offset sits in bits 15:0. The target reported one cycle later is pc + 4 + (sign-extended offset shifted left by 2).
- R3: The equal forms are taken when the two source values match. The not-equal forms are taken when they differ. out_taken is 1 for a taken branch and 0 for every other accepted instruction.
- R4: A plain branch never sets out_squash, and its out_next_pc is pc + 4 whether or not it is taken.
- R5: A likely branch that is not taken sets out_squash, and its out_next_pc is pc + 8. A likely branch that is taken does not set out_squash, and its out_next_pc is pc + 4.
- R6: For the instruction after a branch that was not squashed (the delay slot), out_next_pc is the branch target if the branch was taken. Otherwise it is slot pc + 4. Every other accepted non-branch instruction gives pc + 4.
- R7: retire_count rises by exactly 1 for each accepted instruction that is not flagged unsupported. This includes a likely branch that squashes. A cancelled slot is never presented, so it never counts.
- R8: The allowed opcodes are 0x00, 0x04, 0x05, 0x08 to 0x0F, 0x14 and 0x15. Any other opcode sets out_unsup for one cycle, sets halted until reset, and latches fault_pc and fault_instr. It does not retire, and its out_next_pc equals its own pc.
- R9: A branch opcode presented as the delay slot of a branch is handled as unsupported, as in R8.
- R10: A cycle with in_valid low, or any cycle while halted, gives out_valid = 0 on the next cycle. It leaves out_taken, out_squash and out_unsup at 0 and leaves retire_count and out_next_pc unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | AW | PC of the presented instruction |
| in_rs_val | input | DW | First source register value |
| in_rt_val | input | DW | Second source register value |
| out_valid | output | 1 | Results below belong to the instruction accepted last cycle |
| out_taken | output | 1 | Branch taken |
| out_squash | output | 1 | Delay slot cancelled |
| out_target | output | AW | Branch target address |
| out_next_pc | output | AW | Next fetch address |
| out_unsup | output | 1 | Unsupported instruction pulse |
| halted | output | 1 | Sticky stop after a fault |
| fault_pc | output | AW | PC of the faulting instruction |
| fault_instr | output | 32 | Word of the faulting instruction |
| retire_count | output | CW | Retired instruction count |

## Verification
The assertions assume the core presents the instruction stream in the order given by out_next_pc. In particular, the instruction right after a non-squashed branch is its delay slot, and a squashed slot is never presented. The bench keeps to this by deriving each new pc from the previous result. It issues each branch, then its slot if the slot is not cancelled, then one more instruction. The bench takes the expected addresses from its own target arithmetic. The opcode sweep restarts the unit with a reset before each word, so that a halt left by an earlier word does not mask the next one.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BNE  = 6'h05;
  localparam logic [5:0] OPC_BEQL = 6'h14;
  localparam logic [5:0] OPC_BNEL = 6'h15;

  typedef enum logic [2:0] {
    BK_NONE, BK_EQ, BK_NE, BK_EQ_LIKELY, BK_NE_LIKELY
  } br_kind_t;

  // opcodes the surrounding core can carry out
  function automatic logic opc_known(input logic [5:0] opc);
    return (opc == 6'h00) || (opc == OPC_BEQ) || (opc == OPC_BNE) ||
           (opc[5:3] == 3'b001) || (opc == OPC_BEQL) || (opc == OPC_BNEL);
  endfunction
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
(
  input  logic [31:0] instr,
  output br_kind_t    kind,
  output logic        known,
  output logic [15:0] offset
);
  logic [5:0] opc;
  assign opc    = instr[31:26];
  assign offset = instr[15:0];
  assign known  = opc_known(opc);

  always_comb begin
    unique case (opc)
      OPC_BEQ:  kind = BK_EQ;
      OPC_BNE:  kind = BK_NE;
      OPC_BEQL: kind = BK_EQ_LIKELY;
      OPC_BNEL: kind = BK_NE_LIKELY;
      default:  kind = BK_NONE;
    endcase
  end
endmodule

// File: rtl/bsu_resolve.sv
module bsu_resolve
  import bsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  br_kind_t        kind,
  input  logic [AW-1:0]   pc,
  input  logic [15:0]     offset,
  input  logic [DW-1:0]   rs_val,
  input  logic [DW-1:0]   rt_val,
  output logic            taken,
  output logic            squash,
  output logic [AW-1:0]   target
);
  localparam int EXT_W = AW - 18;
  logic same;
  logic [AW-1:0] disp;

  assign same = (rs_val == rt_val);
  assign disp = {{EXT_W{offset[15]}}, offset, 2'b00};
  assign target = pc + AW'(4) + disp;

  assign taken = ((kind == BK_EQ || kind == BK_EQ_LIKELY) && same) ||
                 ((kind == BK_NE || kind == BK_NE_LIKELY) && !same);

  // one not-taken term per likely form; new forms are OR-ed in here
  assign squash = ((kind == BK_EQ_LIKELY) && !same) ||
                  ((kind == BK_NE_LIKELY) &&  same);
endmodule

// File: rtl/branch_slot_unit.sv
module branch_slot_unit
  import bsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   in_instr,
  input  logic [AW-1:0] in_pc,
  input  logic [DW-1:0] in_rs_val,
  input  logic [DW-1:0] in_rt_val,
  output logic          out_valid,
  output logic          out_taken,
  output logic          out_squash,
  output logic [AW-1:0] out_target,
  output logic [AW-1:0] out_next_pc,
  output logic          out_unsup,
  output logic          halted,
  output logic [AW-1:0] fault_pc,
  output logic [31:0]   fault_instr,
  output logic [CW-1:0] retire_count
);
  br_kind_t      kind;
  logic          known;
  logic [15:0]   offset;
  logic          taken_c, squash_c;
  logic [AW-1:0] target_c;

  bsu_decode u_dec (
    .instr (in_instr), .kind (kind), .known (known), .offset (offset)
  );

  bsu_resolve #(.AW(AW), .DW(DW)) u_res (
    .kind (kind), .pc (in_pc), .offset (offset),
    .rs_val (in_rs_val), .rt_val (in_rt_val),
    .taken (taken_c), .squash (squash_c), .target (target_c)
  );

  logic          slot_pend, slot_take;
  logic [AW-1:0] slot_tgt;
  logic          accept, is_br, bad;

  assign accept = in_valid && !halted;
  assign is_br  = (kind != BK_NONE);
  assign bad    = !known || (slot_pend && is_br);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_squash   <= 1'b0;
      out_unsup    <= 1'b0;
      out_target   <= '0;
      out_next_pc  <= '0;
      halted       <= 1'b0;
      fault_pc     <= '0;
      fault_instr  <= '0;
      retire_count <= '0;
      slot_pend    <= 1'b0;
      slot_take    <= 1'b0;
      slot_tgt     <= '0;
    end else begin
      out_valid  <= accept;
      out_taken  <= 1'b0;
      out_squash <= 1'b0;
      out_unsup  <= 1'b0;
      if (accept) begin
        out_target <= target_c;
        if (bad) begin
          out_unsup   <= 1'b1;
          halted      <= 1'b1;
          fault_pc    <= in_pc;
          fault_instr <= in_instr;
          out_next_pc <= in_pc;
          slot_pend   <= 1'b0;
        end else begin
          retire_count <= retire_count + CW'(1);
          if (slot_pend) begin
            out_next_pc <= slot_take ? slot_tgt : in_pc + AW'(4);
            slot_pend   <= 1'b0;
          end else if (is_br) begin
            out_taken   <= taken_c;
            out_squash  <= squash_c;
            out_next_pc <= squash_c ? in_pc + AW'(8) : in_pc + AW'(4);
            slot_pend   <= !squash_c;
            slot_take   <= taken_c;
            slot_tgt    <= target_c;
          end else begin
            out_next_pc <= in_pc + AW'(4);
          end
        end
      end
    end
  end

  // squash moves fetch two words past the branch
  p_squash_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && !bad && !slot_pend && squash_c) |=> (out_next_pc == $past(in_pc) + AW'(8)));

  // a cancelled slot cannot come from a taken branch
  p_squash_not_taken_r5: assert property (@(posedge clk) disable iff (rst)
    !(out_squash && out_taken));

  // count moves by one per retired instruction only
  p_retire_step_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_unsup) |-> (retire_count == $past(retire_count) + CW'(1)));

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_taken && !out_squash && !out_unsup));

  p_idle_count_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(retire_count));
endmodule

// File: tb/branch_slot_unit_test.sv
module branch_slot_unit_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 32, DW = 32, CW = 32;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [AW-1:0] in_pc = '0;
  logic [DW-1:0] in_rs_val = '0, in_rt_val = '0;
  logic out_valid, out_taken, out_squash, out_unsup, halted;
  logic [AW-1:0] out_target, out_next_pc, fault_pc;
  logic [31:0] fault_instr;
  logic [CW-1:0] retire_count;

  always #2.5 clk = ~clk;

  branch_slot_unit #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk, .rst, .in_valid, .in_instr, .in_pc, .in_rs_val, .in_rt_val,
    .out_valid, .out_taken, .out_squash, .out_target, .out_next_pc,
    .out_unsup, .halted, .fault_pc, .fault_instr, .retire_count
  );

  int tests = 0, fails = 0;
  logic [CW-1:0] exp_ret = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0; exp_ret = '0;
  endtask

  task automatic issue(input logic [5:0] opc, input logic [15:0] off,
                       input logic [AW-1:0] pc, input logic [DW-1:0] a, input logic [DW-1:0] b);
    in_instr = {opc, 5'd1, 5'd2, off}; in_pc = pc; in_rs_val = a; in_rt_val = b;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [AW-1:0] tgt(input logic [AW-1:0] pc, input logic [15:0] off);
    return pc + 32'd4 + ({{16{off[15]}}, off} << 2);
  endfunction

  function automatic bit allowed(input logic [5:0] o);
    return o == 6'h00 || o == 6'h04 || o == 6'h05 || (o >= 6'h08 && o <= 6'h0F) ||
           o == 6'h14 || o == 6'h15;
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [5:0]  kinds [4];
    logic [15:0] offs [6];
    logic [AW-1:0] pc, np, t;
    bit likely, eqform, tk, sq;
    kinds = '{6'h04, 6'h05, 6'h14, 6'h15};
    offs  = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0005};

    do_reset();
    // R1 reset state
    chk(!out_valid && !out_taken && !out_squash && !out_unsup && !halted, "R1 flags",
        {27'd0, out_valid, out_taken, out_squash, out_unsup, halted}, 32'd0);
    chk(retire_count == 0 && out_next_pc == 0 && out_target == 0, "R1 count/pc", retire_count, 32'd0);
    chk(fault_pc == 0 && fault_instr == 0, "R1 fault regs", fault_instr, 32'd0);

    pc = 32'h0000_1000;
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 2; e++) begin
        for (int o = 0; o < 6; o++) begin
          likely = kinds[k][4];
          eqform = !kinds[k][0];
          tk = eqform ? (e == 1) : (e == 0);
          sq = likely && !tk;
          t  = tgt(pc, offs[o]);
          issue(kinds[k], offs[o], pc, 32'h55, (e == 1) ? 32'h55 : 32'h56);
          exp_ret++;
          chk(out_valid, "R2 branch accepted", {31'd0, out_valid}, 32'd1);
          chk(out_target == t, "R2 target", out_target, t);
          chk(out_taken == tk, "R3 taken", {31'd0, out_taken}, {31'd0, tk});
          chk(out_squash == sq, likely ? "R5 squash" : "R4 squash", {31'd0, out_squash}, {31'd0, sq});
          np = sq ? pc + 8 : pc + 4;
          chk(out_next_pc == np, likely ? "R5 next pc" : "R4 next pc", out_next_pc, np);
          chk(retire_count == exp_ret, "R7 branch retire", retire_count, exp_ret);
          if (!sq) begin
            issue(6'h0D, 16'h1234, pc + 4, 32'h0, 32'h0);
            exp_ret++;
            np = tk ? t : pc + 8;
            chk(out_next_pc == np, "R6 slot next pc", out_next_pc, np);
            chk(!out_taken && !out_squash, "R6 slot flags", {30'd0, out_taken, out_squash}, 32'd0);
          end
          issue(6'h09, 16'h0001, np, 32'h0, 32'h0);
          exp_ret++;
          chk(out_next_pc == np + 4, "R6 plain next pc", out_next_pc, np + 4);
          chk(retire_count == exp_ret, "R7 retire", retire_count, exp_ret);
          // R10 idle cycle with garbage on the bus
          in_instr = 32'hFFFF_FFFF;
          @(posedge clk); @(negedge clk);
          chk(!out_valid && retire_count == exp_ret && out_next_pc == np + 4, "R10 idle",
              retire_count, exp_ret);
          pc = pc + 32'h40;
        end
      end
    end

    // R8 opcode sweep, restarting for each word
    for (int op = 0; op < 64; op++) begin
      logic [5:0] oc;
      oc = 6'(op);
      do_reset();
      issue(oc, 16'h0010, 32'h0000_2000, 32'h7, 32'h7);
      chk(out_unsup == !allowed(oc), "R8 unsupported flag", {31'd0, out_unsup}, {31'd0, !allowed(oc)});
      if (!allowed(oc)) begin
        chk(halted && fault_pc == 32'h2000 && fault_instr == {oc, 5'd1, 5'd2, 16'h0010},
            "R8 fault capture", fault_instr, {oc, 5'd1, 5'd2, 16'h0010});
        chk(retire_count == 0 && out_next_pc == 32'h2000, "R8 no retire", retire_count, 32'd0);
        issue(6'h09, 16'h0, 32'h2004, 32'h0, 32'h0);
        chk(!out_valid && retire_count == 0 && halted, "R10 halted ignores input",
            {31'd0, out_valid}, 32'd0);
      end else begin
        chk(retire_count == 1, "R7 allowed retires", retire_count, 32'd1);
      end
    end

    // R9 branch sitting in a delay slot
    do_reset();
    issue(6'h05, 16'h0004, 32'h3000, 32'h1, 32'h2);
    issue(6'h04, 16'h0004, 32'h3004, 32'h1, 32'h1);
    chk(out_unsup && halted && fault_pc == 32'h3004, "R9 branch in slot", fault_pc, 32'h3004);
    chk(retire_count == 1, "R9 retire", retire_count, 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule